// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block finds a setting for a fractional-free PLL: an input divider M, a feedback multiplier N and a post-divider index PL. It starts from a target output frequency and a reference frequency, both unsigned integers in MHz. The setting it keeps is the one whose rounded output lies closest to the target. It also reports the absolute error of that setting, and flags whether the match is exact or whether no legal setting exists at all.

The engine runs over many cycles and has a start/done handshake. A pulse on `start` while the engine is idle captures both frequencies. `busy` then stays high while the engine walks, one step per cycle, through post-divider indices, M values and N candidates. The walk is pruned by a comparison-frequency window and a VCO window. When the search ends, the result registers update and `done` pulses for one cycle. The results then hold until the next search completes. All divisions are combinational integer dividers inside the step logic.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, `busy` and `done` are low, the results read M=255, N=8, PL=1, error all ones (8191), `no_solution` is high and `exact` is low.
- R2: A `start` seen while idle sets `busy` from the next cycle. `busy` then stays high until the cycle in which `done` is high for exactly one cycle. The result outputs change only in that `done` cycle.
- R3: A `start` that arrives while `busy` is high has no effect: the search in progress completes with the result for its own inputs.
- R4: The PL index 0..14 selects the divide ratio 1,2,3,4,5,6,8,10,12,16,12,16,20,24,32. The search covers indices from the low bound to the high bound, inclusive. The low bound is floor(1000/V) and the high bound is ceil(cap/V). Each bound is clamped to 1..32 and then mapped to the first index among 0..13 whose ratio is at least that bound, or to index 14 if none is.
- R5: The VCO target is V = T + T/50. The VCO upper limit `cap` is 1700, raised to V when V exceeds 1700. A candidate qualifies only if floor(ref·N/M) lies within 1000..cap.
- R6: For each PL, M rises from 1 to 255. An M with floor(ref/M) above 38 is skipped. The first M with floor(ref/M) below 12 ends that PL.
- R7: For each accepted M, N runs from floor(T·ratio·M/ref) to the ceiling of the same quotient. A floor value above 255 ends that PL. Candidates below 8 are skipped.
- R8: The output of a qualifying candidate is (VCO + ratio/2)/ratio, and its error is |output − T|. It replaces the kept best only when its error is strictly smaller.
- R9: A candidate with zero error ends the search at once, and `exact` is reported high.
- R10: If no candidate qualifies, the results are M=255, N=8, PL=1, the error is all ones (8191) and `no_solution` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search; taken only when idle |
| in_target | input | FW (12) | Target output frequency, MHz |
| in_ref | input | FW (12) | Reference frequency, MHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results update |
| m_out | output | CW (8) | Chosen input divider |
| n_out | output | CW (8) | Chosen feedback multiplier |
| pl_out | output | 4 | Chosen post-divider table index |
| err_out | output | FW+1 (13) | Absolute error in MHz, all ones when none |
| exact | output | 1 | Error of the result is zero |
| no_solution | output | 1 | No candidate qualified |

## Verification
The bench builds the block with its default parameters: 12-bit frequencies, 8-bit M and N, and a 1000..1700 VCO window. With these values, targets well below 100 MHz drive the high bound past every scanned ratio, which reaches the index-14 fallback. Targets near 1700 MHz raise the VCO cap. References below 12 MHz leave no legal M, and references above 38 MHz force the skip of small M. A sweep across targets and references is compared against an arithmetic model of the search written into the bench.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

    localparam int PL_COUNT = 15;
    localparam int PL_IDX_W = 4;
    localparam int RATIO_W  = 6;

    // Post-divider ratio for each table index (not monotonic past index 9)
    function automatic logic [RATIO_W-1:0] pl_ratio(input logic [PL_IDX_W-1:0] idx);
        logic [RATIO_W-1:0] r;
        case (idx)
            4'd0:    r = 6'd1;
            4'd1:    r = 6'd2;
            4'd2:    r = 6'd3;
            4'd3:    r = 6'd4;
            4'd4:    r = 6'd5;
            4'd5:    r = 6'd6;
            4'd6:    r = 6'd8;
            4'd7:    r = 6'd10;
            4'd8:    r = 6'd12;
            4'd9:    r = 6'd16;
            4'd10:   r = 6'd12;
            4'd11:   r = 6'd16;
            4'd12:   r = 6'd20;
            4'd13:   r = 6'd24;
            default: r = 6'd32;
        endcase
        return r;
    endfunction

    typedef enum logic [1:0] {
        S_IDLE,
        S_BOUND,
        S_MSTEP,
        S_NSTEP
    } srch_state_e;

endpackage

// File: rtl/pll_pl_bounds.sv
module pll_pl_bounds
    import pllsrch_pkg::*;
#(
    parameter int FW      = 12,
    parameter int PW      = 32,
    parameter int VCO_MIN = 1000,
    parameter int VCO_MAX = 1700,
    parameter int DIV_MIN = 1,
    parameter int DIV_MAX = 32
) (
    input  logic [FW-1:0]       tgt,
    output logic [PL_IDX_W-1:0] lo_idx,
    output logic [PL_IDX_W-1:0] hi_idx,
    output logic [PW-1:0]       cap
);
    logic [PW-1:0] vco_tgt;
    logic [PW-1:0] vco_div;
    logic [PW-1:0] hi_bound;
    logic [PW-1:0] lo_bound;

    always_comb begin
        vco_tgt = PW'(tgt) + PW'(tgt) / PW'(50);
        vco_div = (vco_tgt == '0) ? PW'(1) : vco_tgt;
        cap     = (vco_tgt > PW'(VCO_MAX)) ? vco_tgt : PW'(VCO_MAX);

        hi_bound = (cap + vco_div - PW'(1)) / vco_div;
        lo_bound = PW'(VCO_MIN) / vco_div;

        if (hi_bound > PW'(DIV_MAX)) hi_bound = PW'(DIV_MAX);
        if (hi_bound < PW'(DIV_MIN)) hi_bound = PW'(DIV_MIN);
        if (lo_bound > PW'(DIV_MAX)) lo_bound = PW'(DIV_MAX);
        if (lo_bound < PW'(DIV_MIN)) lo_bound = PW'(DIV_MIN);

        // first index (0..COUNT-2) meeting the bound, last index otherwise
        lo_idx = PL_IDX_W'(PL_COUNT - 1);
        hi_idx = PL_IDX_W'(PL_COUNT - 1);
        for (int i = PL_COUNT - 2; i >= 0; i--) begin
            if (PW'(pl_ratio(PL_IDX_W'(i))) >= lo_bound) lo_idx = PL_IDX_W'(i);
            if (PW'(pl_ratio(PL_IDX_W'(i))) >= hi_bound) hi_idx = PL_IDX_W'(i);
        end
    end

endmodule

// File: rtl/pll_m_window.sv
module pll_m_window
    import pllsrch_pkg::*;
#(
    parameter int FW    = 12,
    parameter int CW    = 8,
    parameter int PW    = 32,
    parameter int U_MIN = 12,
    parameter int U_MAX = 38,
    parameter int N_MAX = 255
) (
    input  logic [FW-1:0]       tgt,
    input  logic [FW-1:0]       rf,
    input  logic [PL_IDX_W-1:0] pl,
    input  logic [CW-1:0]       m,
    output logic                u_low,
    output logic                u_high,
    output logic                n_big,
    output logic [PW-1:0]       n_lo,
    output logic [PW-1:0]       n_hi
);
    logic [PW-1:0] rf_div;
    logic [PW-1:0] m_div;
    logic [PW-1:0] cmp_freq;
    logic [PW-1:0] vco_goal;
    logic [PW-1:0] scaled;

    always_comb begin
        rf_div   = (rf == '0) ? PW'(1) : PW'(rf);
        m_div    = (m == '0) ? PW'(1) : PW'(m);
        cmp_freq = PW'(rf) / m_div;
        vco_goal = PW'(tgt) * PW'(pl_ratio(pl));
        scaled   = vco_goal * PW'(m);
        n_lo     = scaled / rf_div;
        n_hi     = (scaled + rf_div - PW'(1)) / rf_div;
        u_low    = cmp_freq < PW'(U_MIN);
        u_high   = cmp_freq > PW'(U_MAX);
        n_big    = n_lo > PW'(N_MAX);
    end

endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval
    import pllsrch_pkg::*;
#(
    parameter int FW      = 12,
    parameter int CW      = 8,
    parameter int PW      = 32,
    parameter int EW      = 13,
    parameter int VCO_MIN = 1000
) (
    input  logic [FW-1:0]       tgt,
    input  logic [FW-1:0]       rf,
    input  logic [PW-1:0]       cap,
    input  logic [CW-1:0]       m,
    input  logic [CW:0]         n,
    input  logic [PL_IDX_W-1:0] pl,
    output logic                ok,
    output logic [EW-1:0]       err
);
    logic [PW-1:0] m_div;
    logic [PW-1:0] vco;
    logic [PW-1:0] ratio;
    logic [PW-1:0] fout;
    logic [PW-1:0] diff;

    always_comb begin
        m_div = (m == '0) ? PW'(1) : PW'(m);
        vco   = (PW'(rf) * PW'(n)) / m_div;
        ratio = PW'(pl_ratio(pl));
        fout  = (vco + (ratio >> 1)) / ratio;
        diff  = (fout >= PW'(tgt)) ? (fout - PW'(tgt)) : (PW'(tgt) - fout);
        ok    = (vco >= PW'(VCO_MIN)) && (vco <= cap);
        err   = EW'(diff);
    end

endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
    import pllsrch_pkg::*;
#(
    parameter int FW      = 12,
    parameter int CW      = 8,
    parameter int VCO_MIN = 1000,
    parameter int VCO_MAX = 1700,
    parameter int U_MIN   = 12,
    parameter int U_MAX   = 38,
    parameter int M_MIN   = 1,
    parameter int M_MAX   = 255,
    parameter int N_MIN   = 8,
    parameter int N_MAX   = 255,
    parameter int DIV_MIN = 1,
    parameter int DIV_MAX = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [FW-1:0]       in_target,
    input  logic [FW-1:0]       in_ref,
    output logic                busy,
    output logic                done,
    output logic [CW-1:0]       m_out,
    output logic [CW-1:0]       n_out,
    output logic [PL_IDX_W-1:0] pl_out,
    output logic [FW:0]         err_out,
    output logic                exact,
    output logic                no_solution
);
    localparam int PW = 2 * FW + 8;
    localparam int EW = FW + 1;
    localparam logic [PL_IDX_W-1:0] PL_DEFAULT = PL_IDX_W'(1);

    typedef struct packed {
        srch_state_e          st;
        logic [FW-1:0]        tgt;
        logic [FW-1:0]        rf;
        logic [PW-1:0]        cap;
        logic [PL_IDX_W-1:0]  pl;
        logic [PL_IDX_W-1:0]  pl_hi;
        logic [CW-1:0]        m;
        logic [CW:0]          n;
        logic [CW:0]          n_end;
        logic [CW-1:0]        best_m;
        logic [CW-1:0]        best_n;
        logic [PL_IDX_W-1:0]  best_pl;
        logic [EW-1:0]        best_err;
        logic [CW-1:0]        res_m;
        logic [CW-1:0]        res_n;
        logic [PL_IDX_W-1:0]  res_pl;
        logic [EW-1:0]        res_err;
        logic                 res_exact;
        logic                 res_none;
        logic                 done;
    } srch_regs_t;

    srch_regs_t q, d;

    logic [PL_IDX_W-1:0] b_lo, b_hi;
    logic [PW-1:0]       b_cap;
    logic                w_u_low, w_u_high, w_n_big;
    logic [PW-1:0]       w_n_lo, w_n_hi;
    logic                c_ok;
    logic [EW-1:0]       c_err;

    pll_pl_bounds #(
        .FW(FW), .PW(PW), .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX),
        .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
    ) u_bounds (
        .tgt    (q.tgt),
        .lo_idx (b_lo),
        .hi_idx (b_hi),
        .cap    (b_cap)
    );

    pll_m_window #(
        .FW(FW), .CW(CW), .PW(PW), .U_MIN(U_MIN), .U_MAX(U_MAX), .N_MAX(N_MAX)
    ) u_mwin (
        .tgt    (q.tgt),
        .rf     (q.rf),
        .pl     (q.pl),
        .m      (q.m),
        .u_low  (w_u_low),
        .u_high (w_u_high),
        .n_big  (w_n_big),
        .n_lo   (w_n_lo),
        .n_hi   (w_n_hi)
    );

    pll_cand_eval #(
        .FW(FW), .CW(CW), .PW(PW), .EW(EW), .VCO_MIN(VCO_MIN)
    ) u_eval (
        .tgt (q.tgt),
        .rf  (q.rf),
        .cap (q.cap),
        .m   (q.m),
        .n   (q.n),
        .pl  (q.pl),
        .ok  (c_ok),
        .err (c_err)
    );

    always_comb begin
        logic go_m;
        logic go_pl;
        logic fin;

        d      = q;
        d.done = 1'b0;
        go_m   = 1'b0;
        go_pl  = 1'b0;
        fin    = 1'b0;

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.tgt      = in_target;
                    d.rf       = in_ref;
                    d.best_m   = CW'(M_MAX);
                    d.best_n   = CW'(N_MIN);
                    d.best_pl  = PL_DEFAULT;
                    d.best_err = '1;
                    d.st       = S_BOUND;
                end
            end
            S_BOUND: begin
                d.cap   = b_cap;
                d.pl    = b_lo;
                d.pl_hi = b_hi;
                d.m     = CW'(M_MIN);
                if (b_lo > b_hi) fin = 1'b1;
                else             d.st = S_MSTEP;
            end
            S_MSTEP: begin
                if (w_u_low || (!w_u_high && w_n_big)) begin
                    go_pl = 1'b1;
                end else if (w_u_high) begin
                    go_m = 1'b1;
                end else begin
                    d.n     = w_n_lo[CW:0];
                    d.n_end = w_n_hi[CW:0];
                    d.st    = S_NSTEP;
                end
            end
            S_NSTEP: begin
                if (q.n > (CW+1)'(N_MAX)) begin
                    go_m = 1'b1;
                end else begin
                    if (q.n >= (CW+1)'(N_MIN) && c_ok && c_err < q.best_err) begin
                        d.best_m   = q.m;
                        d.best_n   = q.n[CW-1:0];
                        d.best_pl  = q.pl;
                        d.best_err = c_err;
                        if (c_err == '0) fin = 1'b1;
                    end
                    if (!fin) begin
                        if (q.n == q.n_end) go_m = 1'b1;
                        else                d.n  = q.n + 1'b1;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (go_m) begin
            if (q.m == CW'(M_MAX)) begin
                go_pl = 1'b1;
            end else begin
                d.m  = q.m + 1'b1;
                d.st = S_MSTEP;
            end
        end

        if (go_pl) begin
            if (q.pl == q.pl_hi) begin
                fin = 1'b1;
            end else begin
                d.pl = q.pl + 1'b1;
                d.m  = CW'(M_MIN);
                d.st = S_MSTEP;
            end
        end

        if (fin) begin
            d.st        = S_IDLE;
            d.done      = 1'b1;
            d.res_m     = d.best_m;
            d.res_n     = d.best_n;
            d.res_pl    = d.best_pl;
            d.res_err   = d.best_err;
            d.res_exact = (d.best_err == '0);
            d.res_none  = (d.best_err == '1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q           <= '0;
            q.st        <= S_IDLE;
            q.res_m     <= CW'(M_MAX);
            q.res_n     <= CW'(N_MIN);
            q.res_pl    <= PL_DEFAULT;
            q.res_err   <= '1;
            q.res_none  <= 1'b1;
            q.res_exact <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.st != S_IDLE);
    assign done        = q.done;
    assign m_out       = q.res_m;
    assign n_out       = q.res_n;
    assign pl_out      = q.res_pl;
    assign err_out     = q.res_err;
    assign exact       = q.res_exact;
    assign no_solution = q.res_none;

endmodule

// File: rtl/pll_coef_search_chk.sv
module pll_coef_search_chk #(
    parameter int FW    = 12,
    parameter int CW    = 8,
    parameter int M_MAX = 255,
    parameter int N_MIN = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] m_out,
    input logic [CW-1:0] n_out,
    input logic [3:0]    pl_out,
    input logic [FW:0]   err_out,
    input logic          exact,
    input logic          no_solution
);
    // R2: done lasts one cycle
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: the engine is idle in the done cycle
    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2: idle without start stays idle
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    // R3: a running search ends only through done, whatever start does
    a_r3_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R2: results move only with done
    a_r2_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(m_out) && $stable(n_out) && $stable(pl_out) && $stable(err_out)));

    // R9: exact flag agrees with the reported error
    a_r9_exact_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (exact == (err_out == '0)));

    // R10: no-solution result carries the defaults
    a_r10_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_solution) |-> (m_out == CW'(M_MAX) && n_out == CW'(N_MIN)
                                   && pl_out == 4'd1 && err_out == '1));

    // R7: a found N respects the lower limit and PL stays in the table
    a_r7_found_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_solution) |-> (n_out >= CW'(N_MIN) && pl_out <= 4'd14));

endmodule

bind pll_coef_search pll_coef_search_chk #(
    .FW(FW), .CW(CW), .M_MAX(M_MAX), .N_MIN(N_MIN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .m_out       (m_out),
    .n_out       (n_out),
    .pl_out      (pl_out),
    .err_out     (err_out),
    .exact       (exact),
    .no_solution (no_solution)
);

// File: tb/sim_pll_coef_search.sv
module sim_pll_coef_search;

    localparam int NONE = 8191;

    typedef struct packed {
        int t;
        int r;
        int m;
        int n;
        int pl;
        int e;
    } vec_t;

    // hand-worked cases
    localparam vec_t VECS [6] = '{
        '{500,  26, 2,   77, 1,  1},    // R8: best improves from err 7 to 1
        '{500,  25, 1,   40, 1,  0},    // R9: exact at ratio 2
        '{500,  100, 3,  30, 1,  0},    // R6: M 1..2 skipped
        '{1700, 27, 1,   63, 0,  1},    // R5: cap raised to 1734
        '{50,   26, 2,   77, 12, 0},    // R4: high bound falls back to index 14
        '{500,  10, 255, 8,  1,  NONE}  // R10: no M passes
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] in_target = '0;
    logic [11:0] in_ref = '0;
    logic        busy, done, exact, no_solution;
    logic [7:0]  m_out, n_out;
    logic [3:0]  pl_out;
    logic [12:0] err_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pll_coef_search u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_target(in_target), .in_ref(in_ref),
        .busy(busy), .done(done), .m_out(m_out), .n_out(n_out),
        .pl_out(pl_out), .err_out(err_out), .exact(exact),
        .no_solution(no_solution)
    );

    function automatic int ratio_of(input int i);
        case (i)
            0: return 1;   1: return 2;   2: return 3;   3: return 4;
            4: return 5;   5: return 6;   6: return 8;   7: return 10;
            8: return 12;  9: return 16;  10: return 12; 11: return 16;
            12: return 20; 13: return 24; default: return 32;
        endcase
    endfunction

    function automatic int first_idx(input int b);
        for (int i = 0; i < 14; i++) if (ratio_of(i) >= b) return i;
        return 14;
    endfunction

    // arithmetic model written from the requirements
    task automatic model(input int t, input int r,
                         output int om, output int on, output int opl, output int oe);
        int v, cap, hb, lb, lo, hi, vg, nl, nh, vco, f, e;
        bit hit;
        v   = t + t / 50;
        cap = (v > 1700) ? v : 1700;
        if (v < 1) v = 1;
        hb = (cap + v - 1) / v;
        lb = 1000 / v;
        if (hb > 32) hb = 32;
        if (hb < 1)  hb = 1;
        if (lb > 32) lb = 32;
        if (lb < 1)  lb = 1;
        lo = first_idx(lb);
        hi = first_idx(hb);
        om = 255; on = 8; opl = 1; oe = NONE; hit = 0;
        for (int pl = lo; pl <= hi && !hit; pl++) begin
            vg = t * ratio_of(pl);
            for (int m = 1; m <= 255 && !hit; m++) begin
                if (r / m < 12) break;
                if (r / m > 38) continue;
                nl = (vg * m) / r;
                nh = (vg * m + r - 1) / r;
                if (nl > 255) break;
                for (int n = nl; n <= nh; n++) begin
                    if (n < 8) continue;
                    if (n > 255) break;
                    vco = (r * n) / m;
                    if (vco >= 1000 && vco <= cap) begin
                        f = (vco + ratio_of(pl) / 2) / ratio_of(pl);
                        e = (f >= t) ? f - t : t - f;
                        if (e < oe) begin
                            om = m; on = n; opl = pl; oe = e;
                            if (e == 0) begin hit = 1; break; end
                        end
                    end
                end
            end
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic launch(input int t, input int r);
        @(negedge clk);
        start     = 1'b1;
        in_target = 12'(t);
        in_ref    = 12'(r);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_res(input string req, input int em, input int en,
                             input int epl, input int ee);
        chk(req, "done", int'(done), 1);
        chk(req, "M", int'(m_out), em);
        chk(req, "N", int'(n_out), en);
        chk(req, "PL", int'(pl_out), epl);
        chk(req, "err", int'(err_out), ee);
        chk(req, "exact", int'(exact), (ee == 0) ? 1 : 0);
        chk(req, "no_solution", int'(no_solution), (ee == NONE) ? 1 : 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int em, en, epl, ee;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "done", int'(done), 0);
        chk("R1", "M", int'(m_out), 255);
        chk("R1", "N", int'(n_out), 8);
        chk("R1", "PL", int'(pl_out), 1);
        chk("R1", "err", int'(err_out), NONE);
        chk("R1", "no_solution", int'(no_solution), 1);
        chk("R1", "exact", int'(exact), 0);

        // table of worked vectors
        for (int i = 0; i < 6; i++) begin
            launch(VECS[i].t, VECS[i].r);
            wait_done();
            check_res($sformatf("R%0d-vec%0d", 0, i), VECS[i].m, VECS[i].n,
                      VECS[i].pl, VECS[i].e);
        end

        // R2: busy after start, results hold, done lasts one cycle
        launch(500, 26);
        chk("R2", "busy after start", int'(busy), 1);
        chk("R2", "result held during search", int'(m_out), 255);
        wait_done();
        check_res("R2", 2, 77, 1, 1);
        @(negedge clk);
        chk("R2", "done width", int'(done), 0);
        chk("R2", "idle after done", int'(busy), 0);

        // R3: start during a search is ignored
        launch(500, 25);
        @(negedge clk);
        start = 1'b1; in_target = 12'd1700; in_ref = 12'd27;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_res("R3", 1, 40, 1, 0);

        // R7: sweep against the model
        for (int t = 100; t <= 1900; t += 150) begin
            foreach (VECS[k]) begin
                if (k < 3) begin
                    int r = (k == 0) ? 19 : (k == 1) ? 26 : 38;
                    model(t, r, em, en, epl, ee);
                    launch(t, r);
                    wait_done();
                    check_res($sformatf("R7 t=%0d r=%0d", t, r), em, en, epl, ee);
                end
            end
        end

        summary();
        $finish;
    end

endmodule